// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store address stage and a data array that is read and written only in aligned pieces. It takes one access at a time, from 1 to 64 bytes for loads and from 1 to 32 bytes for stores. It checks whether the first and the last byte of the access fall in the same aligned piece. The array is read in whole 64-byte lines and written in 32-byte chunks. An access that stays inside one piece becomes a single array request. An access that crosses a piece boundary becomes two requests, always low address first.

For a load, the block collects the two returned lines and shifts out the requested bytes. It sends them upstream as a single right-aligned response, with bytes past the access length set to zero. For a store, it shifts the right-aligned write data into the byte lanes of the two chunks and builds a byte-enable mask for each chunk.

A separate detector flags an access whose bytes span a 4 KB page boundary. A store that does so waits a fixed number of stall cycles before it issues its first chunk write. A load that does so proceeds without delay.

Top module: `misalign_splitter`

## Requirements
- R1: A load whose line offset (address bits [5:0]) plus its length exceeds 64 issues two line reads, at the line-aligned address of its first byte and at that address plus 64. Any other load issues one read at the line-aligned address.
- R2: A store whose chunk offset (address bits [4:0]) plus its length exceeds 32 issues two chunk writes, at the 32-byte-aligned address of its first byte and at that address plus 32. Any other store issues one write at the aligned address.
- R3: A load response holds memory byte address+i in response byte i (bits 8i+7:8i) for every i below the length. All higher response bytes are zero.
- R4: A store writes request byte i (req_wdata bits 8i+7:8i) to memory address+i for every i below the length. dn_be bit j enables byte j of the addressed chunk, and no other memory byte changes.
- R5: The length field req_size_m1 carries length minus one, so 0 means one byte and 63 means 64 bytes. A store length never exceeds 32.
- R6: A store whose first and last bytes lie in different 4 KB pages presents its first chunk write PAGE_STALL (default 33) cycles later than a store that stays in one page. The no-stall case presents its first write in the cycle after acceptance.
- R7: A load presents its first line read in the cycle after acceptance, whether or not it crosses a page.
- R8: After a request is accepted, req_ready stays low until the upstream response handshake completes.
- R9: Sub-requests go out low address first. A load's second line read is issued only after the first line's data has been returned.
- R10: Out of reset, req_ready is high and dn_valid, dn_rsp_ready and up_rsp_valid are low.
- R11: While dn_valid is high and dn_ready is low, dn_valid, dn_addr and the write lanes hold their values. Likewise, up_rsp_valid and up_rsp_data hold while up_rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Upstream access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size_m1 | input | 6 | Access length minus one |
| req_wdata | input | STORE_BYTES*8 | Store data, byte 0 goes to req_addr |
| up_rsp_valid | output | 1 | Access complete (load data valid) |
| up_rsp_ready | input | 1 | Upstream accepts the response |
| up_rsp_data | output | LINE_BYTES*8 | Right-aligned load data, zero for stores |
| dn_valid | output | 1 | Array sub-request valid |
| dn_ready | input | 1 | Array accepts the sub-request |
| dn_store | output | 1 | Sub-request is a chunk write |
| dn_addr | output | ADDR_W | Aligned line or chunk address |
| dn_wdata | output | STORE_BYTES*8 | Chunk write data in lane order |
| dn_be | output | STORE_BYTES | Chunk byte enables, zero for reads |
| dn_rsp_valid | input | 1 | Array returns a line |
| dn_rsp_ready | output | 1 | Block is waiting for a line |
| dn_rsp_data | input | LINE_BYTES*8 | Returned line data |

## Verification
The page-cross stall and the chunk split always meet on the same store. A store that crosses a 4 KB boundary must also cross a 32-byte boundary, so it is both delayed and split in two. The bench provokes this by sweeping every offset and every length of store across the window just below a page boundary. It judges each such store in three ways: the cycle of the first array request, both chunk addresses, and a byte-by-byte comparison of the array model against a shadow copy. The same sweep over loads crosses a line and a page together and expects no delay at all.

// File: rtl/misalign_pkg.sv
// Shared types for the misaligned access splitter.
// Assumes: one access is in flight at a time, so one state variable
// describes the whole block.
package misalign_pkg;

    typedef enum logic [2:0] {
        SP_IDLE   = 3'd0,   // waiting for an access
        SP_STALL  = 3'd1,   // page-cross penalty for stores
        SP_ISSUE0 = 3'd2,   // low-address sub-request
        SP_WAIT0  = 3'd3,   // waiting for the first line
        SP_ISSUE1 = 3'd4,   // high-address sub-request
        SP_WAIT1  = 3'd5,   // waiting for the second line
        SP_RESP   = 3'd6    // response to the requester
    } split_state_t;

endpackage

// File: rtl/span_detect.sv
// Boundary detector: reports whether the first and last byte of an access
// fall into different aligned pieces of GRAN_BYTES bytes.
// Assumes: GRAN_BYTES is a power of two; the address does not wrap.
module span_detect #(
    parameter int ADDR_W     = 16,
    parameter int SZ_W       = 6,
    parameter int GRAN_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size_m1,
    output logic              crosses
);
    localparam int GW = $clog2(GRAN_BYTES);

    logic [ADDR_W-1:0] last_byte;

    // Address of the final byte, then compare piece indices.
    always_comb begin
        last_byte = addr + {{(ADDR_W-SZ_W){1'b0}}, size_m1};
        crosses   = (addr[ADDR_W-1:GW] != last_byte[ADDR_W-1:GW]);
    end
endmodule

// File: rtl/store_steer.sv
// Store lane steering: moves right-aligned store data into the byte lanes
// of two consecutive chunks and builds the byte enables for each chunk.
// Assumes: size_m1 + 1 <= SB; the high chunk is unused when nothing
// spills past the first chunk (its enables are then zero).
module store_steer #(
    parameter int SB   = 32,
    parameter int SZ_W = 6
) (
    input  logic [$clog2(SB)-1:0] offset,
    input  logic [SZ_W-1:0]       size_m1,
    input  logic [SB*8-1:0]       wdata,
    output logic [SB*8-1:0]       lo_data,
    output logic [SB*8-1:0]       hi_data,
    output logic [SB-1:0]         lo_be,
    output logic [SB-1:0]         hi_be
);
    localparam int CW = $clog2(SB);

    logic [2*SB*8-1:0] wide;
    logic [2*SB-1:0]   mask;
    logic [2*SB-1:0]   be_all;
    logic [SZ_W:0]     len;

    // Shift data and a length mask to the chunk offset.
    always_comb begin
        len     = {1'b0, size_m1} + {{SZ_W{1'b0}}, 1'b1};
        wide    = {{(SB*8){1'b0}}, wdata} << {offset, 3'b000};
        mask    = ~({(2*SB){1'b1}} << len);
        be_all  = mask << offset;
        lo_data = wide[SB*8-1:0];
        hi_data = wide[2*SB*8-1:SB*8];
        lo_be   = be_all[SB-1:0];
        hi_be   = be_all[2*SB-1:SB];
    end

    // Offset bits beyond CW do not exist; keep the local name in use.
    if (CW < 1) begin : g_bad_width
        $error("store chunk must hold at least two bytes");
    end
endmodule

// File: rtl/load_merge.sv
// Load merge: joins two returned lines (low line first, little-endian),
// shifts out the accessed bytes and zeroes the bytes past the length.
// Assumes: when the access does not cross, line1 may hold stale data;
// the length mask keeps it out of the result.
module load_merge #(
    parameter int LB   = 64,
    parameter int SZ_W = 6
) (
    input  logic [$clog2(LB)-1:0] offset,
    input  logic [SZ_W-1:0]       size_m1,
    input  logic [LB*8-1:0]       line0,
    input  logic [LB*8-1:0]       line1,
    output logic [LB*8-1:0]       data
);
    logic [2*LB*8-1:0] joined;

    // Concatenate both lines and shift the first byte to lane 0.
    always_comb begin
        joined = {line1, line0} >> {offset, 3'b000};
    end

    // Per-byte length masking.
    for (genvar b = 0; b < LB; b++) begin : g_byte
        localparam logic [SZ_W-1:0] BI = SZ_W'(b);
        assign data[b*8 +: 8] = (BI <= size_m1) ? joined[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/misalign_splitter.sv
// Misaligned access splitter. Accepts one load or store, splits it into
// one or two aligned array requests (64-byte lines for loads, 32-byte
// chunks for stores), inserts a fixed stall before stores that span a
// page, merges load lines into a single right-aligned response.
// Assumes: the array answers loads in order, one line per read; store
// lengths never exceed STORE_BYTES.
module misalign_splitter
    import misalign_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int LINE_BYTES  = 64,
    parameter int STORE_BYTES = 32,
    parameter int PAGE_BYTES  = 4096,
    parameter int PAGE_STALL  = 33,
    localparam int SZ_W       = $clog2(LINE_BYTES),
    localparam int LD         = LINE_BYTES * 8,
    localparam int SD         = STORE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size_m1,
    input  logic [SD-1:0]     req_wdata,
    output logic              up_rsp_valid,
    input  logic              up_rsp_ready,
    output logic [LD-1:0]     up_rsp_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_store,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [SD-1:0]     dn_wdata,
    output logic [STORE_BYTES-1:0] dn_be,
    input  logic              dn_rsp_valid,
    output logic              dn_rsp_ready,
    input  logic [LD-1:0]     dn_rsp_data
);
    localparam int LW    = $clog2(LINE_BYTES);
    localparam int CW    = $clog2(STORE_BYTES);
    localparam int CNT_W = $clog2(PAGE_STALL + 1);

    split_state_t      state;
    logic [CNT_W-1:0]  stall_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [SZ_W-1:0]   size_q;
    logic [SD-1:0]     wdata_q;
    logic              store_q;
    logic              split_q;
    logic [LD-1:0]     line0_q;
    logic [LD-1:0]     line1_q;

    logic line_x, chunk_x, page_x;
    logic [SD-1:0] lo_data, hi_data;
    logic [STORE_BYTES-1:0] lo_be, hi_be;
    logic [LD-1:0] merged;
    logic [ADDR_W-1:0] base_q, step_q;

    // Boundary detectors at the three granularities.
    span_detect #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .GRAN_BYTES(LINE_BYTES)) u_line (
        .addr(req_addr), .size_m1(req_size_m1), .crosses(line_x));
    span_detect #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .GRAN_BYTES(STORE_BYTES)) u_chunk (
        .addr(req_addr), .size_m1(req_size_m1), .crosses(chunk_x));
    span_detect #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .GRAN_BYTES(PAGE_BYTES)) u_page (
        .addr(req_addr), .size_m1(req_size_m1), .crosses(page_x));

    store_steer #(.SB(STORE_BYTES), .SZ_W(SZ_W)) u_steer (
        .offset(addr_q[CW-1:0]), .size_m1(size_q), .wdata(wdata_q),
        .lo_data(lo_data), .hi_data(hi_data), .lo_be(lo_be), .hi_be(hi_be));

    load_merge #(.LB(LINE_BYTES), .SZ_W(SZ_W)) u_merge (
        .offset(addr_q[LW-1:0]), .size_m1(size_q),
        .line0(line0_q), .line1(line1_q), .data(merged));

    // Sequencer: accept, optional stall, one or two sub-requests, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SP_IDLE;
            stall_cnt <= '0;
            addr_q    <= '0;
            size_q    <= '0;
            wdata_q   <= '0;
            store_q   <= 1'b0;
            split_q   <= 1'b0;
            line0_q   <= '0;
            line1_q   <= '0;
        end else begin
            case (state)
                SP_IDLE: if (req_valid) begin
                    addr_q    <= req_addr;
                    size_q    <= req_size_m1;
                    wdata_q   <= req_wdata;
                    store_q   <= req_store;
                    split_q   <= req_store ? chunk_x : line_x;
                    stall_cnt <= CNT_W'(PAGE_STALL - 1);
                    state     <= (req_store && page_x) ? SP_STALL : SP_ISSUE0;
                end
                SP_STALL: begin
                    if (stall_cnt == '0) state <= SP_ISSUE0;
                    else stall_cnt <= stall_cnt - CNT_W'(1);
                end
                SP_ISSUE0: if (dn_ready) begin
                    if (!store_q)     state <= SP_WAIT0;
                    else if (split_q) state <= SP_ISSUE1;
                    else              state <= SP_RESP;
                end
                SP_WAIT0: if (dn_rsp_valid) begin
                    line0_q <= dn_rsp_data;
                    state   <= split_q ? SP_ISSUE1 : SP_RESP;
                end
                SP_ISSUE1: if (dn_ready) begin
                    state <= store_q ? SP_RESP : SP_WAIT1;
                end
                SP_WAIT1: if (dn_rsp_valid) begin
                    line1_q <= dn_rsp_data;
                    state   <= SP_RESP;
                end
                SP_RESP: if (up_rsp_ready) state <= SP_IDLE;
                default: state <= SP_IDLE;
            endcase
        end
    end

    // Aligned base and second-piece stride for the latched access.
    always_comb begin
        if (store_q) begin
            base_q = {addr_q[ADDR_W-1:CW], {CW{1'b0}}};
            step_q = ADDR_W'(STORE_BYTES);
        end else begin
            base_q = {addr_q[ADDR_W-1:LW], {LW{1'b0}}};
            step_q = ADDR_W'(LINE_BYTES);
        end
    end

    // Handshake outputs and sub-request fields.
    always_comb begin
        req_ready    = (state == SP_IDLE);
        dn_valid     = (state == SP_ISSUE0) || (state == SP_ISSUE1);
        dn_rsp_ready = (state == SP_WAIT0) || (state == SP_WAIT1);
        up_rsp_valid = (state == SP_RESP);
        up_rsp_data  = store_q ? '0 : merged;
        dn_store     = store_q;
        dn_addr      = (state == SP_ISSUE1) ? base_q + step_q : base_q;
        dn_wdata     = (state == SP_ISSUE1) ? hi_data : lo_data;
        dn_be        = !store_q ? '0 : ((state == SP_ISSUE1) ? hi_be : lo_be);
    end

    // ---------------- assertions ----------------
    p_dn_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_be));

    p_up_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_data));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_store_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store |-> req_size_m1 < SZ_W'(STORE_BYTES));

    p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, dn_valid, dn_rsp_ready, up_rsp_valid}));

    p_be_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_store && !split_q
        |-> $countones(dn_be) == int'(size_q) + 1);

    p_line_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rsp_valid && dn_rsp_ready && split_q && (state == SP_WAIT0)
        |=> dn_valid && dn_addr[LW-1:0] == '0);
endmodule

// File: tb/misalign_splitter_test.sv
// Bench: sweeps every offset and length over two address regions, one of
// them straddling a page boundary, with an array model that stalls its
// ready in a fixed pattern. Expected values come from byte arithmetic.
module misalign_splitter_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int LB  = 64;
    localparam int SB  = 32;
    localparam int PST = 33;
    localparam int WIN = 'hF80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [5:0] req_size_m1 = '0;
    logic [SB*8-1:0] req_wdata = '0;
    logic up_rsp_valid, up_rsp_ready = 1'b1;
    logic [LB*8-1:0] up_rsp_data;
    logic dn_valid, dn_ready = 1'b1, dn_store;
    logic [AW-1:0] dn_addr;
    logic [SB*8-1:0] dn_wdata;
    logic [SB-1:0] dn_be;
    logic dn_rsp_valid = 1'b0, dn_rsp_ready;
    logic [LB*8-1:0] dn_rsp_data = '0;

    int checks = 0, fails = 0, cyc = 0;
    int t_acc = 0, t_first = 0, nsub = 0;
    bit seen_first = 0, order_bad = 0;
    int sub_addr [4];
    logic [7:0] win [0:255];
    logic [7:0] shadow [0:255];

    misalign_splitter uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_addr(req_addr), .req_size_m1(req_size_m1),
        .req_wdata(req_wdata), .up_rsp_valid(up_rsp_valid),
        .up_rsp_ready(up_rsp_ready), .up_rsp_data(up_rsp_data),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_store(dn_store),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_be(dn_be),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
        .dn_rsp_data(dn_rsp_data));

    initial forever #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13) + ((a >> 8) * 7) + 'h21);
    endfunction

    function automatic logic [7:0] mem_rd(input int a);
        if (a >= WIN && a < WIN + 256) return win[a - WIN];
        return pat(a);
    endfunction

    task automatic check(input bit ok, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", what);
        end
    endtask

    // Array model: accepts sub-requests, writes enabled bytes, returns lines.
    initial begin
        bit hs_req, hs_rsp, pend, prev_wait, c_store;
        int pend_addr, c_addr;
        logic [SB*8-1:0] c_wd;
        logic [SB-1:0] c_be;
        logic [AW-1:0] prev_addr;
        pend = 0; prev_wait = 0; prev_addr = '0;
        for (int i = 0; i < 256; i++) begin
            win[i] = pat(WIN + i);
            shadow[i] = pat(WIN + i);
        end
        forever begin
            @(negedge clk);
            if (prev_wait)
                check(dn_valid && dn_addr == prev_addr,
                      $sformatf("R11 held request act v=%0b a=%h exp a=%h",
                                dn_valid, dn_addr, prev_addr));
            prev_wait = dn_valid && !dn_ready;
            prev_addr = dn_addr;
            if (dn_valid && !seen_first) begin
                seen_first = 1;
                t_first = cyc;
            end
            hs_req = dn_valid && dn_ready;
            hs_rsp = dn_rsp_valid && dn_rsp_ready;
            c_addr = int'(dn_addr); c_store = dn_store; c_wd = dn_wdata; c_be = dn_be;
            @(posedge clk);
            #1;
            if (hs_rsp) pend = 0;
            if (hs_req) begin
                if (nsub < 4) sub_addr[nsub] = c_addr;
                nsub++;
                if (c_store) begin
                    for (int j = 0; j < SB; j++)
                        if (c_be[j] && (c_addr + j) >= WIN && (c_addr + j) < WIN + 256)
                            win[c_addr + j - WIN] = c_wd[j*8 +: 8];
                end else begin
                    if (pend) order_bad = 1;
                    pend = 1;
                    pend_addr = c_addr;
                end
            end
            dn_rsp_valid = pend;
            for (int j = 0; j < LB; j++) dn_rsp_data[j*8 +: 8] = mem_rd(pend_addr + j);
            dn_ready = (cyc % 5) != 2;
        end
    end

    task automatic access(input bit st, input int a, input int sz,
                          input logic [SB*8-1:0] wd, output logic [LB*8-1:0] rd,
                          output int lat, output bit busy_bad);
        @(negedge clk);
        req_store = st; req_addr = AW'(a); req_size_m1 = 6'(sz - 1);
        req_wdata = wd; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        t_acc = cyc; seen_first = 0; nsub = 0; order_bad = 0;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        busy_bad = 0;
        forever begin
            @(negedge clk);
            if (up_rsp_valid) break;
            if (req_ready) busy_bad = 1;
        end
        rd = up_rsp_data;
        lat = t_first - t_acc;
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input int a, input int sz);
        logic [LB*8-1:0] rd, exp_d;
        int lat, base;
        bit bb, split;
        for (int i = 0; i < LB; i++) exp_d[i*8 +: 8] = (i < sz) ? mem_rd(a + i) : 8'h00;
        access(0, a, sz, '0, rd, lat, bb);
        check(rd == exp_d, $sformatf("R3 load a=%h n=%0d act %h exp %h", a, sz, rd, exp_d));
        if (sz == 1 || sz == 64)
            check(rd == exp_d, $sformatf("R5 length code %0d act %h exp %h", sz - 1, rd, exp_d));
        split = (a % 64) + sz > 64;
        base = a & ~63;
        check(nsub == (split ? 2 : 1),
              $sformatf("R1 read count a=%h n=%0d act %0d exp %0d", a, sz, nsub, split ? 2 : 1));
        check(sub_addr[0] == base, $sformatf("R1 first line act %h exp %h", sub_addr[0], base));
        if (split)
            check(sub_addr[1] == base + 64,
                  $sformatf("R9 second line act %h exp %h", sub_addr[1], base + 64));
        check(lat == 1, $sformatf("R7 load issue delay a=%h act %0d exp 1", a, lat));
        check(!bb, $sformatf("R8 ready while busy act 1 exp 0 a=%h", a));
        check(!order_bad, $sformatf("R9 line read before data act 1 exp 0 a=%h", a));
    endtask

    task automatic do_store(input int a, input int sz, input int k);
        logic [SB*8-1:0] wd;
        logic [LB*8-1:0] rd;
        int lat, base, bad_i, exp_lat;
        bit bb, split, pc;
        for (int i = 0; i < SB; i++) wd[i*8 +: 8] = 8'(a * 5 + sz * 11 + i * 3 + k);
        for (int i = 0; i < sz; i++) shadow[a + i - WIN] = wd[i*8 +: 8];
        access(1, a, sz, wd, rd, lat, bb);
        bad_i = -1;
        for (int i = 0; i < 256; i++) if (bad_i < 0 && win[i] != shadow[i]) bad_i = i;
        check(bad_i < 0, $sformatf("R4 store a=%h n=%0d byte %h act %h exp %h", a, sz,
              WIN + bad_i, (bad_i < 0) ? 8'h0 : win[bad_i], (bad_i < 0) ? 8'h0 : shadow[bad_i]));
        split = (a % 32) + sz > 32;
        base = a & ~31;
        check(nsub == (split ? 2 : 1),
              $sformatf("R2 write count a=%h n=%0d act %0d exp %0d", a, sz, nsub, split ? 2 : 1));
        check(sub_addr[0] == base, $sformatf("R2 first chunk act %h exp %h", sub_addr[0], base));
        if (split)
            check(sub_addr[1] == base + 32,
                  $sformatf("R9 second chunk act %h exp %h", sub_addr[1], base + 32));
        pc = (a >> 12) != ((a + sz - 1) >> 12);
        exp_lat = pc ? 1 + PST : 1;
        check(lat == exp_lat, $sformatf("R6 store issue delay a=%h n=%0d act %0d exp %0d",
              a, sz, lat, exp_lat));
        check(!bb, $sformatf("R8 ready while busy act 1 exp 0 a=%h", a));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !dn_valid && !dn_rsp_ready && !up_rsp_valid,
              $sformatf("R10 reset outputs act rdy=%0b dv=%0b rr=%0b uv=%0b exp 1 0 0 0",
                        req_ready, dn_valid, dn_rsp_ready, up_rsp_valid));
        // Stores: one region inside a page, one straddling 0x1000.
        for (int o = 0; o < 32; o++)
            for (int n = 1; n <= 32; n++) begin
                do_store(WIN + o, n, k); k++;
                do_store('hFE0 + o, n, k); k++;
            end
        // Loads: full sweep in one page, stepped lengths across the page edge.
        for (int o = 0; o < 64; o++)
            for (int n = 1; n <= 64; n++) do_load('h100 + o, n);
        for (int o = 0; o < 64; o++)
            for (int n = 1; n <= 64; n += 3) do_load('hFC0 + o, n);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule